// File: doc/BRIEF.md
# Per-Core Countdown Timer with Vectored Interrupt

This block is a private countdown timer for one processor core. Software reaches it through four word registers on a small memory-mapped bus. A control register holds an interrupt vector number, a mask bit and a mode bit. An initial-count register sets the length of the countdown. A read-only current-count register shows how far the countdown has gone. A divide register selects how many clock cycles make up one countdown step.

Writing a nonzero initial count loads the current count and starts the countdown. Writing zero stops it. When the count runs out, the block emits a one-cycle interrupt pulse that carries the programmed vector. A busy flag then stays up until the receiving controller acknowledges it. In one-shot mode the count then rests at zero. In periodic mode it reloads from the initial count and keeps going. Setting the mask suppresses the pulse, but counting continues.

Top module: `cntdn_timer`

## Requirements
- R1: After reset, the control register reads 0x0001_0000 (mask set, one-shot mode, vector 0, not busy), and the initial count, current count and divide registers all read 0.
- R2: The control register returns the vector in bits 7:0, the mask in bit 16 and the mode in bit 17, as written. Bit 12 is the busy flag; writes to bit 12 are ignored, and all other control bits read 0.
- R3: The divide code is {bit 3, bit 1, bit 0} of the divide register. Codes 0 to 6 make one countdown step every 2, 4, 8, 16, 32, 64 and 128 cycles respectively, and code 7 makes one step every cycle. Bit 2 and bits 31:4 of the divide register read 0. The step phase restarts whenever the initial count or the divide register is written.
- R4: Writing the initial count (offset 0x380) loads the same value into the current count (offset 0x390) on that clock edge. A nonzero value starts the countdown. A zero value stops the timer, and no interrupt is raised afterwards.
- R5: In one-shot mode (bit 17 = 0), the step that takes the count from 1 to 0 raises irq_pulse for exactly one cycle with irq_vector equal to the programmed vector. The current count then stays at 0 until the initial count is rewritten.
- R6: In periodic mode (bit 17 = 1), the step that would reach zero reloads the current count from the initial count and raises a pulse. With an initial count N and a divide code of 7, this gives one pulse every N cycles.
- R7: While the mask is set (bit 16 = 1), counting and reloading continue unchanged, but no pulse is emitted and busy is not set.
- R8: The busy flag rises in the same cycle as each emitted pulse and clears one cycle after irq_ack is sampled high. If a new pulse and an acknowledge fall in the same cycle, busy stays set.
- R9: Writes to the current-count offset (0x390) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector number sent with irq_pulse |
| irq_ack | input | 1 | Acknowledge from the interrupt controller; clears busy |

## Verification
Two events can fall in the same cycle: the expiry that sets busy and the acknowledge that clears it. The bench holds irq_ack high from before the countdown starts, so the acknowledge is present on the very edge where the count expires. It then reads the control register twice. Right after the pulse, busy must read 1, because the new event wins. One cycle later it must read 0, because the still-held acknowledge clears it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 8;
    localparam int PRE_W  = 7;   // wide enough for the largest divisor minus one (127)

    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h320;
    localparam logic [ADDR_W-1:0] OFF_INIT = 12'h380;
    localparam logic [ADDR_W-1:0] OFF_CUR  = 12'h390;
    localparam logic [ADDR_W-1:0] OFF_DIV  = 12'h3E0;

    localparam int BIT_BUSY = 12;
    localparam int BIT_MASK = 16;
    localparam int BIT_MODE = 17;

    typedef enum logic {
        MODE_ONCE   = 1'b0,
        MODE_REPEAT = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e        mode;
        logic             mask;
        logic [VEC_W-1:0] vector;
    } tmr_ctrl_t;

    // The three scattered divide bits, gathered into one code.
    function automatic logic [2:0] gather_code(input logic [DATA_W-1:0] w);
        return {w[3], w[1], w[0]};
    endfunction

    // Last prescaler value before a step: the divisor minus one.
    function automatic logic [PRE_W-1:0] step_limit(input logic [2:0] code);
        logic [PRE_W:0] d;
        if (code == 3'b111) begin
            return '0;
        end
        d = (PRE_W+1)'(2) << code;
        return PRE_W'(d - 1'b1);
    endfunction

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              busy,
    input  logic [CNT_W-1:0]  cur_count,
    output tmr_ctrl_t         ctrl,
    output logic [CNT_W-1:0]  init_q,
    output logic [2:0]        code_q,
    output logic              load,
    output logic              div_wr,
    output logic [DATA_W-1:0] rdata
);

    logic ctrl_wr;

    assign ctrl_wr = wr_en && (addr == OFF_CTRL);
    assign load    = wr_en && (addr == OFF_INIT);
    assign div_wr  = wr_en && (addr == OFF_DIV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl.mode   <= MODE_ONCE;
            ctrl.mask   <= 1'b1;
            ctrl.vector <= '0;
            init_q      <= '0;
            code_q      <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl.mode   <= tmr_mode_e'(wdata[BIT_MODE]);
                ctrl.mask   <= wdata[BIT_MASK];
                ctrl.vector <= wdata[VEC_W-1:0];
            end
            if (load) begin
                init_q <= CNT_W'(wdata);
            end
            if (div_wr) begin
                code_q <= gather_code(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: begin
                rdata[VEC_W-1:0] = ctrl.vector;
                rdata[BIT_BUSY]  = busy;
                rdata[BIT_MASK]  = ctrl.mask;
                rdata[BIT_MODE]  = ctrl.mode;
            end
            OFF_INIT: rdata = DATA_W'(init_q);
            OFF_CUR:  rdata = DATA_W'(cur_count);
            OFF_DIV:  rdata = {28'b0, code_q[2], 1'b0, code_q[1:0]};
            default:  rdata = '0;
        endcase
    end

    // R2: the busy bit seen on a control read follows the core, not the write data
    a_r2_busy_readonly: assert property (@(posedge clk) disable iff (rst)
        (addr == OFF_CTRL) |-> (rdata[BIT_BUSY] == busy));

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic [2:0]       code,
    output logic             tick
);

    logic [PRE_W-1:0] phase;
    logic [PRE_W-1:0] limit;

    assign limit = step_limit(code);
    assign tick  = (phase == limit);

    always_ff @(posedge clk) begin
        if (rst || restart || tick) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R3: with any divisor above one, two steps never come back to back
    a_r3_no_double_step: assert property (@(posedge clk) disable iff (rst)
        (tick && code != 3'b111 && !restart && $stable(code)) |=> !tick);

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             tick,
    input  tmr_ctrl_t        ctrl,
    input  logic             ack,
    output logic [CNT_W-1:0] cur,
    output logic             pulse,
    output logic [VEC_W-1:0] vec_out,
    output logic             busy
);

    logic expire;
    logic emit;

    assign expire = !load && tick && (cur == CNT_W'(1));
    assign emit   = expire && !ctrl.mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            pulse   <= 1'b0;
            vec_out <= '0;
            busy    <= 1'b0;
        end else begin
            if (load) begin
                cur <= load_val;
            end else if (tick && cur != '0) begin
                if (cur == CNT_W'(1)) begin
                    cur <= (ctrl.mode == MODE_REPEAT) ? reload_val : '0;
                end else begin
                    cur <= cur - 1'b1;
                end
            end
            pulse <= emit;
            if (emit) begin
                vec_out <= ctrl.vector;
            end
            if (emit) begin
                busy <= 1'b1;
            end else if (ack) begin
                busy <= 1'b0;
            end
        end
    end

    // R5: a one-shot expiry yields a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (pulse && ctrl.mode == MODE_ONCE && $stable(ctrl.mode)) |=> !pulse);

    // R7: a pulse only follows a cycle in which the mask was clear
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        pulse |-> !$past(ctrl.mask));

    // R8: busy is always up alongside a pulse
    a_r8_busy_with_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |-> busy);

    // R8: an acknowledge with no new pulse drops busy
    a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (busy && ack && !emit) |=> !busy);

endmodule

// File: rtl/cntdn_timer.sv
module cntdn_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_pulse,
    output logic [7:0]        irq_vector,
    input  logic              irq_ack
);

    tmr_ctrl_t        ctrl;
    logic [CNT_W-1:0] init_q;
    logic [CNT_W-1:0] cur;
    logic [2:0]       code_q;
    logic             load;
    logic             div_wr;
    logic             tick;
    logic             busy;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .busy      (busy),
        .cur_count (cur),
        .ctrl      (ctrl),
        .init_q    (init_q),
        .code_q    (code_q),
        .load      (load),
        .div_wr    (div_wr),
        .rdata     (reg_rdata)
    );

    tmr_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .restart (load || div_wr),
        .code    (code_q),
        .tick    (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .load       (load),
        .load_val   (CNT_W'(reg_wdata)),
        .reload_val (init_q),
        .tick       (tick),
        .ctrl       (ctrl),
        .ack        (irq_ack),
        .cur        (cur),
        .pulse      (irq_pulse),
        .vec_out    (irq_vector),
        .busy       (busy)
    );

    // R4: a write of the initial count appears in the current count on the next cycle
    a_r4_load_visible: assert property (@(posedge clk) disable iff (rst)
        load |=> (cur == $past(CNT_W'(reg_wdata))));

endmodule

// File: tb/cntdn_timer_test.sv
module cntdn_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_pulse;
    logic [7:0]  irq_vector;
    logic        irq_ack;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;
    logic [7:0] last_vec = '0;

    localparam logic [11:0] A_CTRL = 12'h320;
    localparam logic [11:0] A_INIT = 12'h380;
    localparam logic [11:0] A_CUR  = 12'h390;
    localparam logic [11:0] A_DIV  = 12'h3E0;

    always #5 clk = ~clk;

    cntdn_timer uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse),
        .irq_vector(irq_vector), .irq_ack(irq_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // advance n edges, sampling at each falling edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (irq_pulse) begin
                pulses++;
                last_vec = irq_vector;
            end
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        if (irq_pulse) begin
            pulses++;
            last_vec = irq_vector;
        end
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic quiesce();
        wr(A_CTRL, 32'h0001_0000);
        wr(A_INIT, 32'h0);
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        pulses = 0;
    endtask

    task automatic t_reset();
        rd(A_CTRL, 32'h0001_0000, "R1 ctrl");
        rd(A_INIT, 32'h0, "R1 init");
        rd(A_CUR,  32'h0, "R1 cur");
        rd(A_DIV,  32'h0, "R1 div");
        check("R1 no pulse", {31'b0, irq_pulse}, 32'h0);
    endtask

    task automatic t_regs();
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, 32'h0003_00FF, "R2 ctrl readback, busy ignored");
        wr(A_DIV, 32'hFFFF_FFFF);
        rd(A_DIV, 32'h0000_000B, "R3 div reserved zero");
        wr(A_DIV, 32'h0000_0004);
        rd(A_DIV, 32'h0, "R3 div bit2 zero");
        wr(A_CUR, 32'h0000_1234);
        rd(A_CUR, 32'h0, "R9 cur write ignored");
        quiesce();
    endtask

    task automatic t_divide();
        wr(A_DIV, 32'h0000_000B);          // code 7: every cycle
        wr(A_INIT, 32'd10);
        step(4);
        rd(A_CUR, 32'd6, "R3 code7 step per cycle");
        wr(A_DIV, 32'h0000_0000);          // code 0: every 2
        wr(A_INIT, 32'd10);
        step(4);
        rd(A_CUR, 32'd8, "R3 code0 divide by 2");
        wr(A_DIV, 32'h0000_0003);          // code 3: every 16
        wr(A_INIT, 32'd40);
        rd(A_INIT, 32'd40, "R4 init readback");
        rd(A_CUR, 32'd40, "R4 load into cur");
        step(31);
        rd(A_CUR, 32'd39, "R3 code3 before second step");
        step(1);
        rd(A_CUR, 32'd38, "R3 code3 second step");
        wr(A_CUR, 32'd5);
        step(1);
        rd(A_CUR, 32'd38, "R9 cur write ignored while running");
        wr(A_DIV, 32'h0000_000B);
        quiesce();
    endtask

    task automatic t_oneshot();
        wr(A_CTRL, 32'h0000_005A);
        wr(A_INIT, 32'd3);
        step(2);
        check("R5 no early pulse", pulses, 0);
        step(1);
        check("R5 pulse at expiry", {31'b0, irq_pulse}, 32'h1);
        check("R5 vector", {24'b0, irq_vector}, 32'h5A);
        rd(A_CUR, 32'd0, "R5 count zero");
        rd(A_CTRL, 32'h0000_105A, "R8 busy set");
        step(6);
        check("R5 single pulse", pulses, 1);
        rd(A_CUR, 32'd0, "R5 stays zero");
        irq_ack = 1'b1;
        step(1);
        irq_ack = 1'b0;
        rd(A_CTRL, 32'h0000_005A, "R8 ack clears busy");
        quiesce();
    endtask

    task automatic t_periodic();
        wr(A_CTRL, 32'h0002_0033);
        wr(A_INIT, 32'd4);
        step(6);
        check("R6 first pulse", pulses, 1);
        check("R6 vector", {24'b0, last_vec}, 32'h33);
        rd(A_CUR, 32'd2, "R6 reload then count");
        step(14);
        check("R6 pulse every 4", pulses, 5);
        quiesce();
    endtask

    task automatic t_mask();
        wr(A_CTRL, 32'h0003_0000);
        wr(A_INIT, 32'd3);
        step(4);
        rd(A_CUR, 32'd2, "R7 counting continues masked");
        step(9);
        check("R7 no pulse masked", pulses, 0);
        rd(A_CTRL, 32'h0003_0000, "R7 busy not set");
        quiesce();
    endtask

    task automatic t_stop();
        wr(A_CTRL, 32'h0002_0011);
        wr(A_INIT, 32'd5);
        step(2);
        rd(A_CUR, 32'd3, "R4 countdown started");
        wr(A_INIT, 32'd0);
        step(10);
        check("R4 zero write stops", pulses, 0);
        rd(A_CUR, 32'd0, "R4 count zero after stop");
        quiesce();
    endtask

    task automatic t_race();
        irq_ack = 1'b1;
        wr(A_CTRL, 32'h0000_0077);
        wr(A_INIT, 32'd2);
        step(2);
        check("R8 race pulse", {31'b0, irq_pulse}, 32'h1);
        rd(A_CTRL, 32'h0000_1077, "R8 pulse wins over ack");
        step(1);
        rd(A_CTRL, 32'h0000_0077, "R8 held ack clears next");
        irq_ack = 1'b0;
        quiesce();
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; irq_ack = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_regs();
        t_divide();
        t_oneshot();
        t_periodic();
        t_mask();
        t_stop();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule